// File: doc/BRIEF.md
# Packed Keyboard Character Buffer

This block sits between a key-decode stage and a host interrupt-test read path. Each key event carries a small key identifier and a kind (press, release or repeat). The block follows five modifier keys: left shift, right shift, left control, right control and caps lock. When a character key is pressed, it picks one of five codes for that key by modifier priority. The chosen code goes into a single packed register that holds up to three characters.

Occupancy is a thermometer field (empty, one, two, three). A fourth character merges into the newest slot and raises an overrun flag. The host takes one character per drain request. The reply word carries the device number with its low bit cleared, the oldest character and the overrun flag. After a drain, the remaining characters move up one slot. A pending output stays high while any character is held. A one-cycle interrupt pulse marks every stored character.

Top module: `kbd_buffer`

## Requirements
- R1: After reset the buffer is empty: `key_pending`, `rsp_valid` and `ext_irq` are 0 and all modifiers are released.
- R2: Characters leave in arrival order. The oldest character is returned in `rsp_word[23:16]` one cycle after the drain request. The next character then becomes the oldest.
- R3: A character that arrives while three are held is ORed into the newest slot and sets the overrun flag. The next drain reports overrun in `rsp_word[4]` and clears the flag, so later drains report 0 there.
- R4: A drain reply carries `dev_id` with bit 0 cleared in `rsp_word[31:24]`. Bits 15:5 and 3:0 are zero.
- R5: `key_pending` is 1 while at least one character is held. It falls in the cycle after the last character is drained.
- R6: While `host_kbd_mask` is 1, a drain request returns nothing (`rsp_valid` stays 0) and leaves the buffer unchanged.
- R7: Each stored character gives a one-cycle `ext_irq` pulse in the cycle after the key event.
- R8: Code choice: if either control is held, the control code is used. Otherwise, caps lock with shift gives the shift+caps code, and caps lock alone gives the caps code. Otherwise, shift gives the shifted code, and with no modifier the normal code is used. Key ids 0..25 are letters: normal 0x61+id, shifted and caps 0x41+id, shift+caps 0x61+id, control id+1. Key ids 26..35 are digits (k = id-26): normal and caps 0x30+k, shifted and shift+caps 0x20+k, control 0x30+k.
- R9: Modifier key ids are 40 left shift, 41 right shift, 42 left control, 43 right control and 44 caps lock. Each side is tracked on its own. A press sets the modifier and a release clears it.
- R10: Event kinds are 0 press, 1 release and 2 repeat. Repeats, releases of character keys, and any key id other than 0..35 and 40..44 store nothing.
- R11: A drain request while empty returns nothing and changes no state.
- R12: A drain and a character key press in the same cycle return the old oldest character. The new character is appended after the shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Key event strobe |
| ev_kind | input | 2 | 0 press, 1 release, 2 repeat |
| ev_key | input | 6 | Key identifier |
| host_kbd_mask | input | 1 | Keyboard delivery blocked while 1 |
| dev_id | input | DEV_W | Device number placed in replies |
| drain_req | input | 1 | Interrupt-test read strobe |
| rsp_valid | output | 1 | Reply carries a character |
| rsp_word | output | 32 | Reply word |
| key_pending | output | 1 | At least one character held |
| ext_irq | output | 1 | One-cycle pulse per stored character |

## Verification
A wrong occupancy field shows up in the same cycle at `key_pending`. It also shows up on the next drain, as a missing reply, an extra reply or a character out of place. A stuck overrun flag appears in bit 4 of the drain after the one that should have cleared it. A misrouted shift position gives a wrong or merged character code within one drain. Modifier flags that are held wrongly are visible one cycle after the next character press, in the code returned by the following drain.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  localparam int KEY_W = 6;
  localparam int CH_W  = 8;

  localparam logic [1:0] EV_PRESS   = 2'd0;
  localparam logic [1:0] EV_RELEASE = 2'd1;

  localparam logic [KEY_W-1:0] KEY_SHIFT_L = 6'd40;
  localparam logic [KEY_W-1:0] KEY_SHIFT_R = 6'd41;
  localparam logic [KEY_W-1:0] KEY_CTRL_L  = 6'd42;
  localparam logic [KEY_W-1:0] KEY_CTRL_R  = 6'd43;
  localparam logic [KEY_W-1:0] KEY_CAPS    = 6'd44;

  typedef struct packed {
    logic shift_l;
    logic shift_r;
    logic ctrl_l;
    logic ctrl_r;
    logic caps;
  } mods_t;

  typedef struct packed {
    logic            valid;
    logic [CH_W-1:0] norm;
    logic [CH_W-1:0] shifted;
    logic [CH_W-1:0] capsed;
    logic [CH_W-1:0] shcaps;
    logic [CH_W-1:0] ctrl;
  } key_codes_t;

  function automatic key_codes_t key_lookup(input logic [KEY_W-1:0] id);
    key_codes_t      c;
    logic [CH_W-1:0] idx;
    logic [CH_W-1:0] k;
    idx = CH_W'(id);
    k   = idx - 8'd26;
    c   = '0;
    if (id < 6'd26) begin
      c.valid   = 1'b1;
      c.norm    = 8'h61 + idx;
      c.shifted = 8'h41 + idx;
      c.capsed  = 8'h41 + idx;
      c.shcaps  = 8'h61 + idx;
      c.ctrl    = idx + 8'd1;
    end else if (id < 6'd36) begin
      c.valid   = 1'b1;
      c.norm    = 8'h30 + k;
      c.shifted = 8'h20 + k;
      c.capsed  = 8'h30 + k;
      c.shcaps  = 8'h20 + k;
      c.ctrl    = 8'h30 + k;
    end
    return c;
  endfunction
endpackage

// File: rtl/kbd_modifiers.sv
module kbd_modifiers
  import kbd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  input  logic [1:0]       ev_kind,
  input  logic [KEY_W-1:0] ev_key,
  output logic             char_valid,
  output logic [CH_W-1:0]  char_code
);
  mods_t      mods_q, mods_n;
  key_codes_t codes;
  logic       is_press, is_rel, any_shift, any_ctrl;

  always_comb begin
    is_press = ev_valid && (ev_kind == EV_PRESS);
    is_rel   = ev_valid && (ev_kind == EV_RELEASE);
    mods_n   = mods_q;
    if (is_press || is_rel) begin
      case (ev_key)
        KEY_SHIFT_L: mods_n.shift_l = is_press;
        KEY_SHIFT_R: mods_n.shift_r = is_press;
        KEY_CTRL_L:  mods_n.ctrl_l  = is_press;
        KEY_CTRL_R:  mods_n.ctrl_r  = is_press;
        KEY_CAPS:    mods_n.caps    = is_press;
        default:     mods_n         = mods_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mods_q <= '0;
    else if (is_press || is_rel) mods_q <= mods_n;
  end

  // code selection by modifier priority, using flags held before this event
  always_comb begin
    codes      = key_lookup(ev_key);
    any_shift  = mods_q.shift_l | mods_q.shift_r;
    any_ctrl   = mods_q.ctrl_l | mods_q.ctrl_r;
    char_valid = is_press && codes.valid;
    if (any_ctrl)         char_code = codes.ctrl;
    else if (mods_q.caps) char_code = any_shift ? codes.shcaps : codes.capsed;
    else if (any_shift)   char_code = codes.shifted;
    else                  char_code = codes.norm;
  end
endmodule

// File: rtl/kbd_pack_buffer.sv
module kbd_pack_buffer #(
  parameter int SLOTS = 3,
  parameter int CH_W  = 8,
  parameter int DEV_W = 8,
  parameter int RSP_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             char_valid,
  input  logic [CH_W-1:0]  char_code,
  input  logic             drain_req,
  input  logic             host_kbd_mask,
  input  logic [DEV_W-1:0] dev_id,
  output logic             rsp_valid,
  output logic [RSP_W-1:0] rsp_word,
  output logic             key_pending,
  output logic             ext_irq
);
  localparam int BUF_W = SLOTS * CH_W;
  localparam int PAD_W = RSP_W - DEV_W - CH_W - 5;

  logic [BUF_W-1:0] buf_q, buf_d, buf_n;
  logic [SLOTS-1:0] occ_q, occ_d, occ_n, prev_occ;
  logic             ovf_q, ovf_d, ovf_n;
  logic             take, upd;
  logic [CH_W-1:0]  head;
  logic [RSP_W-1:0] rsp_n;
  logic             rsp_valid_q, irq_q;
  logic [RSP_W-1:0] rsp_word_q;

  assign head = buf_q[BUF_W-1 -: CH_W];
  assign take = drain_req && occ_q[0] && !host_kbd_mask;
  assign upd  = take || char_valid;

  always_comb begin
    buf_d = buf_q;
    occ_d = occ_q;
    ovf_d = ovf_q;
    if (take) begin
      buf_d = buf_q << CH_W;
      occ_d = occ_q >> 1;
      ovf_d = 1'b0;
    end
    buf_n    = buf_d;
    occ_n    = occ_d;
    ovf_n    = ovf_d;
    prev_occ = {occ_d[SLOTS-2:0], 1'b1};
    if (char_valid) begin
      if (occ_d[SLOTS-1]) begin
        buf_n[CH_W-1:0] = buf_d[CH_W-1:0] | char_code;
        ovf_n           = 1'b1;
      end else begin
        for (int i = 0; i < SLOTS; i++) begin
          if (!occ_d[i] && prev_occ[i]) buf_n[(SLOTS-i)*CH_W-1 -: CH_W] = char_code;
        end
        occ_n = {occ_d[SLOTS-2:0], 1'b1};
      end
    end
    rsp_n = {dev_id & ~DEV_W'(1), head, PAD_W'(0), ovf_q, 4'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      occ_q <= '0;
      ovf_q <= 1'b0;
    end else if (upd) begin
      buf_q <= buf_n;
      occ_q <= occ_n;
      ovf_q <= ovf_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      irq_q       <= 1'b0;
      rsp_word_q  <= '0;
    end else begin
      rsp_valid_q <= take;
      irq_q       <= char_valid;
      if (take) rsp_word_q <= rsp_n;
    end
  end

  assign rsp_valid   = rsp_valid_q;
  assign rsp_word    = rsp_word_q;
  assign key_pending = occ_q[0];
  assign ext_irq     = irq_q;
endmodule

// File: rtl/kbd_buffer.sv
module kbd_buffer
  import kbd_pkg::*;
#(
  parameter int SLOTS = 3,
  parameter int DEV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  input  logic [1:0]       ev_kind,
  input  logic [KEY_W-1:0] ev_key,
  input  logic             host_kbd_mask,
  input  logic [DEV_W-1:0] dev_id,
  input  logic             drain_req,
  output logic             rsp_valid,
  output logic [31:0]      rsp_word,
  output logic             key_pending,
  output logic             ext_irq
);
  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic            char_valid;
  logic [CH_W-1:0] char_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  kbd_modifiers i_mods (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .ev_valid   (ev_valid),
    .ev_kind    (ev_kind),
    .ev_key     (ev_key),
    .char_valid (char_valid),
    .char_code  (char_code)
  );

  kbd_pack_buffer #(.SLOTS(SLOTS), .CH_W(CH_W), .DEV_W(DEV_W), .RSP_W(32)) i_pack (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .char_valid    (char_valid),
    .char_code     (char_code),
    .drain_req     (drain_req),
    .host_kbd_mask (host_kbd_mask),
    .dev_id        (dev_id),
    .rsp_valid     (rsp_valid),
    .rsp_word      (rsp_word),
    .key_pending   (key_pending),
    .ext_irq       (ext_irq)
  );
endmodule

// File: rtl/kbd_buffer_chk.sv
module kbd_buffer_chk #(
  parameter int DEV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev_valid,
  input logic [1:0]       ev_kind,
  input logic [5:0]       ev_key,
  input logic             host_kbd_mask,
  input logic [DEV_W-1:0] dev_id,
  input logic             drain_req,
  input logic             rsp_valid,
  input logic [31:0]      rsp_word,
  input logic             key_pending,
  input logic             ext_irq
);
  // R7
  irq_has_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_irq |-> key_pending);

  // R11
  empty_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_req && !key_pending) |=> !rsp_valid);

  // R6
  masked_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_req && host_kbd_mask) |=> !rsp_valid);

  // R4
  rsp_format_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!rsp_word[24] && rsp_word[15:5] == '0 && rsp_word[3:0] == '0));

  // R10
  pending_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_pending) |-> $past(ev_valid && ev_kind == 2'd0));

  // R5
  rsp_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(key_pending));
endmodule

bind kbd_buffer kbd_buffer_chk #(.DEV_W(DEV_W)) i_chk (.*);

// File: tb/test_kbd_buffer.sv
module test_kbd_buffer;
  localparam int CLK_P = 10;
  localparam int NV    = 25;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ev_valid, host_kbd_mask, drain_req;
  logic [1:0]  ev_kind;
  logic [5:0]  ev_key;
  logic [7:0]  dev_id;
  logic        rsp_valid, key_pending, ext_irq;
  logic [31:0] rsp_word;
  int          total = 0;
  int          bad   = 0;

  // row: {kind, key, stores, expected code}
  localparam logic [16:0] VEC [0:NV-1] = '{
    {2'd0, 6'd0,  1'b1, 8'h61}, {2'd0, 6'd40, 1'b0, 8'h00},
    {2'd0, 6'd0,  1'b1, 8'h41}, {2'd0, 6'd44, 1'b0, 8'h00},
    {2'd0, 6'd0,  1'b1, 8'h61}, {2'd1, 6'd40, 1'b0, 8'h00},
    {2'd0, 6'd0,  1'b1, 8'h41}, {2'd0, 6'd27, 1'b1, 8'h31},
    {2'd0, 6'd43, 1'b0, 8'h00}, {2'd0, 6'd2,  1'b1, 8'h03},
    {2'd1, 6'd44, 1'b0, 8'h00}, {2'd0, 6'd2,  1'b1, 8'h03},
    {2'd1, 6'd43, 1'b0, 8'h00}, {2'd0, 6'd41, 1'b0, 8'h00},
    {2'd0, 6'd27, 1'b1, 8'h21}, {2'd0, 6'd40, 1'b0, 8'h00},
    {2'd1, 6'd41, 1'b0, 8'h00}, {2'd0, 6'd1,  1'b1, 8'h42},
    {2'd2, 6'd1,  1'b0, 8'h00}, {2'd1, 6'd1,  1'b0, 8'h00},
    {2'd0, 6'd50, 1'b0, 8'h00}, {2'd1, 6'd40, 1'b0, 8'h00},
    {2'd0, 6'd35, 1'b1, 8'h39}, {2'd2, 6'd44, 1'b0, 8'h00},
    {2'd0, 6'd0,  1'b1, 8'h61}
  };

  kbd_buffer i_kbd_buffer (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_key(ev_key),
    .host_kbd_mask(host_kbd_mask), .dev_id(dev_id), .drain_req(drain_req),
    .rsp_valid(rsp_valid), .rsp_word(rsp_word), .key_pending(key_pending), .ext_irq(ext_irq)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ev_valid = 1'b0; ev_kind = 2'd0; ev_key = '0;
    host_kbd_mask = 1'b0; drain_req = 1'b0; dev_id = 8'h35;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // caller stands at a negedge; returns at the negedge after the storing edge
  task automatic send(input logic [1:0] k, input logic [5:0] key);
    ev_valid = 1'b1; ev_kind = k; ev_key = key;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic drain();
    drain_req = 1'b1;
    @(negedge clk);
    drain_req = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    bad++;
    $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1
    chk(key_pending == 1'b0, "R1 pending", 32'(key_pending), 32'd0);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 32'd0);
    chk(ext_irq == 1'b0, "R1 irq", 32'(ext_irq), 32'd0);

    // R8 R9 R10 table walk
    for (int i = 0; i < NV; i++) begin
      logic st;
      logic [7:0] ch;
      st = VEC[i][8];
      ch = VEC[i][7:0];
      send(VEC[i][16:15], VEC[i][14:9]);
      chk(ext_irq == st, $sformatf("R7 R10 irq row %0d", i), 32'(ext_irq), 32'(st));
      chk(key_pending == st, $sformatf("R10 pending row %0d", i), 32'(key_pending), 32'(st));
      if (st) begin
        drain();
        chk(rsp_valid && rsp_word[23:16] == ch, $sformatf("R8 R9 code row %0d", i),
            {23'd0, rsp_valid, rsp_word[23:16]}, {23'd1, ch});
        chk(!key_pending, $sformatf("R5 empty row %0d", i), 32'(key_pending), 32'd0);
      end
    end

    // R1 modifiers cleared by reset
    do_reset();
    send(2'd0, 6'd40);
    do_reset();
    send(2'd0, 6'd3);
    drain();
    chk(rsp_word[23:16] == 8'h64, "R1 modifiers clear", 32'(rsp_word[23:16]), 32'h64);

    // R11 empty drain
    drain();
    chk(!rsp_valid, "R11 empty drain", 32'(rsp_valid), 32'd0);
    chk(!key_pending, "R11 still empty", 32'(key_pending), 32'd0);

    // R2 R3 R4 R5 ordering and overrun
    send(2'd0, 6'd0); send(2'd0, 6'd1); send(2'd0, 6'd2); send(2'd0, 6'd3);
    drain();
    chk(rsp_word[23:16] == 8'h61, "R2 first", 32'(rsp_word[23:16]), 32'h61);
    chk(rsp_word[4] == 1'b1, "R3 overrun seen", 32'(rsp_word[4]), 32'd1);
    chk(rsp_word[31:24] == 8'h34, "R4 device", 32'(rsp_word[31:24]), 32'h34);
    chk(rsp_word[15:0] == 16'h0010, "R4 low bits", 32'(rsp_word[15:0]), 32'h10);
    drain();
    chk(rsp_word[23:16] == 8'h62, "R2 second", 32'(rsp_word[23:16]), 32'h62);
    chk(rsp_word[4] == 1'b0, "R3 overrun cleared", 32'(rsp_word[4]), 32'd0);
    chk(key_pending, "R5 still pending", 32'(key_pending), 32'd1);
    drain();
    chk(rsp_word[23:16] == 8'h67, "R3 merged", 32'(rsp_word[23:16]), 32'h67);
    chk(!key_pending, "R5 drained", 32'(key_pending), 32'd0);

    // R6 mask
    send(2'd0, 6'd4);
    host_kbd_mask = 1'b1;
    drain();
    chk(!rsp_valid, "R6 masked", 32'(rsp_valid), 32'd0);
    chk(key_pending, "R6 kept", 32'(key_pending), 32'd1);
    host_kbd_mask = 1'b0;
    drain();
    chk(rsp_valid && rsp_word[23:16] == 8'h65, "R6 after unmask",
        32'(rsp_word[23:16]), 32'h65);

    // R12 drain with simultaneous store
    send(2'd0, 6'd0); send(2'd0, 6'd1);
    ev_valid = 1'b1; ev_kind = 2'd0; ev_key = 6'd2; drain_req = 1'b1;
    @(negedge clk);
    ev_valid = 1'b0; drain_req = 1'b0;
    chk(rsp_word[23:16] == 8'h61, "R12 old head", 32'(rsp_word[23:16]), 32'h61);
    drain();
    chk(rsp_word[23:16] == 8'h62, "R12 second", 32'(rsp_word[23:16]), 32'h62);
    drain();
    chk(rsp_word[23:16] == 8'h63, "R12 appended", 32'(rsp_word[23:16]), 32'h63);
    chk(!key_pending, "R12 empty", 32'(key_pending), 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule